// File: doc/BRIEF.md
# Nibble-Swapping Discrete Bank Latch

This block is the bank-select latch of a cartridge on an 8-bit CPU bus. Every CPU write to the upper half of the 64 KB address space captures the data byte into an internal register. The stored byte then produces two bank numbers. One is a 32 KB program bank and the other is an 8 KB pattern bank.

Before the byte is split, its two nibbles may be exchanged. On the first board variant, the exchange follows one outer-mode bit. On every other variant, it follows one bit of the outer program base. An outer bank value and an outer mode byte arrive on input ports. They supply the high program bank bits, they set how many low program bits come from the latch, and they pick the nametable mirroring. The bank outputs are combinational from the stored byte and the outer inputs. A change to the outer inputs therefore takes effect without a new bus write.

Top module: `nibswap_bank_latch`

## Requirements
- R1: After reset the stored byte is 0x00. The pattern bank then reads 0, and the program bank equals the outer base with its masked low bits forced to 0.
- R2: A clock edge with cpuWrEn high and cpuAddr[15] high stores cpuData. The outputs reflect the new byte from that edge onward.
- R3: A write with cpuAddr[15] low does not change the stored byte. A cycle with cpuWrEn low does not change it either.
- R4: The inner program mask is 2 bits wide (0x3) when outerMode[3] is 0, and 1 bit wide (0x1) when outerMode[3] is 1.
- R5: When boardVariant1 is 1, the nibbles are exchanged exactly when outerMode[3] is 0.
- R6: When boardVariant1 is 0, the nibbles are exchanged exactly when outerPrg[13] is 1.
- R7: prgBank = (value AND mask) OR (base AND NOT mask). Here base = (outerPrg >> 2) OR (outerMode[2] << 1), and value is the byte after any exchange.
- R8: chrBank equals bits 7:4 of the value after any exchange.
- R9: mirrorHorz equals outerMode[4]. A value of 1 selects horizontal mirroring and 0 selects vertical.
- R10: The stored byte keeps its raw order. Changing the outer inputs alone recomputes every output from the same stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | CPU write cycle qualifier |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| boardVariant1 | input | 1 | Strap: 1 selects the first board variant |
| outerMode | input | 8 | Outer mode byte (bits 2, 3, 4 used) |
| outerPrg | input | 16 | Outer program base value |
| prgBank | output | 14 | 32 KB program bank number |
| chrBank | output | 4 | 8 KB pattern bank number |
| mirrorHorz | output | 1 | 1 selects horizontal mirroring, 0 selects vertical |

## Verification
The hardest case to reach from the ports is a change of the swap decision while the stored byte stays fixed. This case shows that the block keeps the raw byte and applies the exchange downstream. The stimulus reaches it by writing one asymmetric byte, such as 0x5A, once. It then walks both strap values and flips outerMode[3] and outerPrg[13] over several idle cycles, checking both banks each time. Random cycles mix writes above and below 0x8000 with random outer values.

// File: rtl/nibswap_bank_pkg.sv
package nibswap_bank_pkg;
  typedef struct packed {
    logic loadEn;
    logic swapSel;
    logic narrowMask;
  } latchCtrl_t;
endpackage

// File: rtl/nibswap_bank_ctrl.sv
module nibswap_bank_ctrl
  import nibswap_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PRG_W  = 16,
  parameter int MODE_W = 8,
  parameter int SWAP_PRG_BIT = 13
) (
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              boardVariant1,
  input  logic [MODE_W-1:0] outerMode,
  input  logic [PRG_W-1:0]  outerPrg,
  output latchCtrl_t        ctrl
);
  localparam int TOP_BIT = ADDR_W - 1;

  always_comb begin
    ctrl.loadEn     = cpuWrEn && cpuAddr[TOP_BIT];
    ctrl.narrowMask = outerMode[3];
    if (boardVariant1) ctrl.swapSel = !outerMode[3];
    else               ctrl.swapSel = outerPrg[SWAP_PRG_BIT];
  end
endmodule

// File: rtl/nibswap_bank_dp.sv
module nibswap_bank_dp
  import nibswap_bank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRG_W  = 16,
  parameter int MODE_W = 8,
  parameter int CHR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  latchCtrl_t        ctrl,
  input  logic [DATA_W-1:0] cpuData,
  input  logic [MODE_W-1:0] outerMode,
  input  logic [PRG_W-1:0]  outerPrg,
  output logic [PRG_W-3:0]  prgBank,
  output logic [CHR_W-1:0]  chrBank,
  output logic              mirrorHorz
);
  localparam int BANK_W = PRG_W - 2;
  localparam int HALF   = DATA_W / 2;

  logic [DATA_W-1:0] latchQ;
  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] value;
  logic [BANK_W-1:0] base;
  logic [BANK_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (!rst_n)           latchQ <= '0;
    else if (ctrl.loadEn) latchQ <= cpuData;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_swap
    assign swapped[i] = latchQ[(i + HALF) % DATA_W];
  end

  always_comb begin
    value      = ctrl.swapSel ? swapped : latchQ;
    mask       = ctrl.narrowMask ? BANK_W'(1) : BANK_W'(3);
    base       = outerPrg[PRG_W-1:2];
    base[1]    = base[1] | outerMode[2];
    prgBank    = (BANK_W'(value) & mask) | (base & ~mask);
    chrBank    = value[DATA_W-1 -: CHR_W];
    mirrorHorz = outerMode[4];
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.loadEn |=> latchQ == $past(cpuData));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.loadEn |=> $stable(latchQ));
  assert_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.narrowMask |-> prgBank[BANK_W-1:1] == base[BANK_W-1:1]);
  assert_plain_chr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.swapSel |-> chrBank == latchQ[DATA_W-1 -: CHR_W]);
  assert_swap_chr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.swapSel |-> chrBank == latchQ[CHR_W-1:0]);
endmodule

// File: rtl/nibswap_bank_latch.sv
module nibswap_bank_latch
  import nibswap_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PRG_W  = 16,
  parameter int MODE_W = 8,
  parameter int CHR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              boardVariant1,
  input  logic [MODE_W-1:0] outerMode,
  input  logic [PRG_W-1:0]  outerPrg,
  output logic [PRG_W-3:0]  prgBank,
  output logic [CHR_W-1:0]  chrBank,
  output logic              mirrorHorz
);
  latchCtrl_t ctrl;

  nibswap_bank_ctrl #(.ADDR_W(ADDR_W), .PRG_W(PRG_W), .MODE_W(MODE_W)) u_ctrl (
    .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr), .boardVariant1(boardVariant1),
    .outerMode(outerMode), .outerPrg(outerPrg), .ctrl(ctrl)
  );

  nibswap_bank_dp #(.DATA_W(DATA_W), .PRG_W(PRG_W), .MODE_W(MODE_W), .CHR_W(CHR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cpuData(cpuData),
    .outerMode(outerMode), .outerPrg(outerPrg),
    .prgBank(prgBank), .chrBank(chrBank), .mirrorHorz(mirrorHorz)
  );
endmodule

// File: tb/tb_nibswap_bank_latch.sv
module tb_nibswap_bank_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        boardVariant1 = 1'b0;
  logic [7:0]  outerMode = '0;
  logic [15:0] outerPrg = '0;
  logic [13:0] prgBank;
  logic [3:0]  chrBank;
  logic        mirrorHorz;

  int checks = 0;
  int failures = 0;
  logic [7:0] expLatch = '0;

  always #5 clk = ~clk;

  nibswap_bank_latch dut (
    .clk(clk), .rst_n(rst_n), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr),
    .cpuData(cpuData), .boardVariant1(boardVariant1), .outerMode(outerMode),
    .outerPrg(outerPrg), .prgBank(prgBank), .chrBank(chrBank),
    .mirrorHorz(mirrorHorz)
  );

  function automatic logic [7:0] modelValue(logic [7:0] b);
    logic sw = boardVariant1 ? !outerMode[3] : outerPrg[13];
    return sw ? {b[3:0], b[7:4]} : b;
  endfunction

  function automatic logic [13:0] modelPrg(logic [7:0] b);
    logic [13:0] base = outerPrg[15:2] | {12'd0, outerMode[2], 1'b0};
    logic [13:0] mask = outerMode[3] ? 14'd1 : 14'd3;
    return ({6'd0, modelValue(b)} & mask) | (base & ~mask);
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic checkAll(string req);
    check({req, " prg"}, int'(prgBank), int'(modelPrg(expLatch)));
    check({req, " chr"}, int'(chrBank), int'(modelValue(expLatch) >> 4));
    check({req, " mirror R9"}, int'(mirrorHorz), int'(outerMode[4]));
  endtask

  // Drive at negedge, let one posedge pass, sample at the next negedge.
  task automatic busCycle(logic we, logic [15:0] a, logic [7:0] d);
    cpuWrEn = we; cpuAddr = a; cpuData = d;
    @(posedge clk);
    if (rst_n && we && a[15]) expLatch = d;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    outerPrg = 16'hA4F0; outerMode = 8'h04;
    busCycle(1'b1, 16'h8000, 8'hFF);   // write while reset held
    rst_n = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");
    check("R1 chr zero", int'(chrBank), 0);

    // R2 load, R3 ignored writes
    boardVariant1 = 1'b0; outerPrg = 16'h0000; outerMode = 8'h00;
    busCycle(1'b1, 16'h8000, 8'h5A);
    check("R2 load chr", int'(chrBank), 5);
    check("R2 load prg", int'(prgBank), 2);
    busCycle(1'b1, 16'h7FFF, 8'hC3);
    check("R3 low addr chr", int'(chrBank), 5);
    busCycle(1'b0, 16'hFFFF, 8'hC3);
    check("R3 no write prg", int'(prgBank), 2);

    // R4/R5/R6/R10 with one stored byte 0x5A
    boardVariant1 = 1'b1; outerMode = 8'h00; @(negedge clk);
    check("R5 swap chr", int'(chrBank), 4'hA);
    check("R4 wide mask prg", int'(prgBank), 2'b01);
    outerMode = 8'h08; @(negedge clk);
    check("R5 no swap chr", int'(chrBank), 5);
    check("R4 narrow mask prg", int'(prgBank), 0);
    boardVariant1 = 1'b0; outerPrg = 16'h2000; outerMode = 8'h00; @(negedge clk);
    check("R6 swap chr", int'(chrBank), 4'hA);
    check("R10 prg recompute", int'(prgBank), 14'h0801);
    outerPrg = 16'h1FFC; @(negedge clk);
    check("R6 no swap chr", int'(chrBank), 5);
    check("R7 base bits", int'(prgBank), 14'h07FE);
    outerMode = 8'h14; @(negedge clk);
    check("R9 horizontal", int'(mirrorHorz), 1);
    checkAll("R7 mode2");

    // random mix
    for (int n = 0; n < 400; n++) begin
      boardVariant1 = 1'($urandom);
      outerMode = 8'($urandom);
      outerPrg = 16'($urandom);
      busCycle(1'($urandom), 16'($urandom), 8'($urandom));
      checkAll("R2 R3 R7 R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule